// File: doc/BRIEF.md
# Microprogram Sequencer with Format-Selected Microwords

This block is the control engine of a microcoded processor. It holds a 6-bit control address register, a resident control store of 64 sixteen-bit microwords, and the logic that picks the next control address on every clock. The microword at the current address is read combinationally. Its top bit selects one of two meanings. A control-format word drives its fifteen low bits straight onto the control outputs and then steps to the next address. A branch-format word drives no control signal and only decides where sequencing goes next.

A branch word can step on, jump, jump on one selected ALU condition flag, dispatch to the routine of the current machine opcode, call a micro-subroutine or return from one. Return addresses are kept on a four-entry stack. A call on a full stack or a return on an empty one sets a sticky error output, which only reset clears. The control address is also brought out so the datapath can see where the sequencer is.

There is no data stream through this block. Every pin is a plain level that is sampled or updated once per clock, so no valid/ready handshake and no back-pressure apply. One microword is retired on every cycle.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the control address becomes 0, the return stack is emptied and `stk_err` becomes 0. Address 0 is where the fetch routine starts.
- R2: Microword bit 15 is the format bit. When it is 0, `ctrl` equals bits 14:0 of the word and the next address is the current address plus one. The address wraps from 63 to 0.
- R3: When bit 15 is 1, `ctrl` is all zero. The operation is read from bits 14:12: 0 step, 1 jump, 2 conditional jump, 3 dispatch, 4 call, 5 return, 6 and 7 step. The flag index is in bits 9:8 and the target address is in bits 5:0.
- R4: A jump loads the target into the control address on the next edge.
- R5: A conditional jump loads the target when `flags[index]` is 1. Otherwise it steps to the current address plus one.
- R6: A dispatch loads `opcode*4 + 16`.
- R7: A call pushes the current address plus one and loads the target. A return pops the most recent entry into the control address. Calls nest up to four deep and return in last-in, first-out order.
- R8: A call while four entries are held sets `stk_err`, leaves the stack unchanged and still loads the target.
- R9: A return while the stack is empty sets `stk_err` and steps to the current address plus one.
- R10: Once `stk_err` is 1, it stays 1 until reset.
- R11: `opcode` has no effect except on a dispatch word, and `flags` has no effect except on a conditional jump word.
- R12: The resident program is as follows, with unlisted addresses holding an all-zero control word. Control words: 0→0x0001, 1→0x0002, 2→0x0004, 16→0x0010, 21→0x0020, 25→0x0080, 41→0x0400, 45→0x0800, 48→0x0040, 52→0x0100, 56→0x0200. Branch words: 3 dispatch; 20 conditional on flag 0 to 48; 28 conditional on flag 3 to 56; 24 call 52; 32 call 58; 58 call 52; 36 call 36; 53, 59 and 40 return; 44 step; 17, 22, 26, 29, 33, 42, 46, 49 and 57 jump 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 3 | Machine opcode used by a dispatch word |
| flags | input | 4 | ALU condition flags tested by a conditional jump |
| ctrl | output | 15 | Control signals of the current microword |
| uaddr | output | 6 | Current control address |
| stk_err | output | 1 | Sticky return-stack overflow/underflow error |

## Verification
The assertions assume that `rst_n` is driven low at the first clock edge. They also assume that `opcode` and `flags` are stable, known values at every rising edge, since the dispatch and conditional properties compare the next address against their sampled values. The stimulus meets these conditions by starting in reset and by changing inputs only on the falling edge. It changes opcode and flags only between routines or while the sequencer is parked in a loop, so every decision point sees settled inputs.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int ADDR_W     = 6;
  localparam int WORD_W     = 16;
  localparam int CTRL_W     = WORD_W - 1;
  localparam int OPC_W      = 3;
  localparam int FLAG_W     = 4;
  localparam int STACK_D    = 4;
  localparam int DISP_BASE  = 16;
  localparam int DISP_SHIFT = 2;

  // bit positions shared by store and next-address logic
  localparam int FMT_BIT  = 15;
  localparam int OP_HI    = 14;
  localparam int OP_LO    = 12;
  localparam int SEL_HI   = 9;
  localparam int SEL_LO   = 8;
  localparam int TGT_HI   = 5;

  typedef enum logic [2:0] {
    BR_STEP = 3'd0,
    BR_JUMP = 3'd1,
    BR_JCND = 3'd2,
    BR_DISP = 3'd3,
    BR_CALL = 3'd4,
    BR_RET  = 3'd5,
    BR_RS6  = 3'd6,
    BR_RS7  = 3'd7
  } br_op_e;

  function automatic logic [WORD_W-1:0] br_word(br_op_e op, logic [1:0] sel,
                                                logic [ADDR_W-1:0] tgt);
    return {1'b1, op, 2'b00, sel, 2'b00, tgt};
  endfunction

  function automatic logic [WORD_W-1:0] ct_word(logic [CTRL_W-1:0] c);
    return {1'b0, c};
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int WW = WORD_W
) (
  input  logic [AW-1:0] addr,
  output logic [WW-1:0] word
);

  logic [WORD_W-1:0] raw;

  always_comb begin
    case (int'(addr))
      // fetch: three transfer steps, then enter the opcode routine
      0:  raw = ct_word(15'h0001);
      1:  raw = ct_word(15'h0002);
      2:  raw = ct_word(15'h0004);
      3:  raw = br_word(BR_DISP, 2'd0, 6'd0);
      // opcode 0
      16: raw = ct_word(15'h0010);
      17: raw = br_word(BR_JUMP, 2'd0, 6'd0);
      // opcode 1: test flag 0
      20: raw = br_word(BR_JCND, 2'd0, 6'd48);
      21: raw = ct_word(15'h0020);
      22: raw = br_word(BR_JUMP, 2'd0, 6'd0);
      // opcode 2: single-level subroutine
      24: raw = br_word(BR_CALL, 2'd0, 6'd52);
      25: raw = ct_word(15'h0080);
      26: raw = br_word(BR_JUMP, 2'd0, 6'd0);
      // opcode 3: test flag 3
      28: raw = br_word(BR_JCND, 2'd3, 6'd56);
      29: raw = br_word(BR_JUMP, 2'd0, 6'd0);
      // opcode 4: nested subroutines
      32: raw = br_word(BR_CALL, 2'd0, 6'd58);
      33: raw = br_word(BR_JUMP, 2'd0, 6'd0);
      // opcode 5: runaway self-call
      36: raw = br_word(BR_CALL, 2'd0, 6'd36);
      // opcode 6: return with nothing stacked
      40: raw = br_word(BR_RET, 2'd0, 6'd0);
      41: raw = ct_word(15'h0400);
      42: raw = br_word(BR_JUMP, 2'd0, 6'd0);
      // opcode 7: explicit step word
      44: raw = br_word(BR_STEP, 2'd0, 6'd0);
      45: raw = ct_word(15'h0800);
      46: raw = br_word(BR_JUMP, 2'd0, 6'd0);
      // out-of-line pieces
      48: raw = ct_word(15'h0040);
      49: raw = br_word(BR_JUMP, 2'd0, 6'd0);
      52: raw = ct_word(15'h0100);
      53: raw = br_word(BR_RET, 2'd0, 6'd0);
      56: raw = ct_word(15'h0200);
      57: raw = br_word(BR_JUMP, 2'd0, 6'd0);
      58: raw = br_word(BR_CALL, 2'd0, 6'd52);
      59: raw = br_word(BR_RET, 2'd0, 6'd0);
      default: raw = '0;
    endcase
  end

  assign word = WW'(raw);

endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int AW    = 6,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_req,
  input  logic          ret_req,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top,
  output logic          empty,
  output logic          err
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] entry [DEPTH];
  logic [CW-1:0] count;
  logic          full;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign wr_idx = IW'(count);
  assign rd_idx = IW'(count - CW'(1));
  assign top    = empty ? '0 : entry[rd_idx];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)
          entry[g] <= '0;
        else if (call_req && !full && wr_idx == IW'(g))
          entry[g] <= push_addr;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      err   <= 1'b0;
    end else begin
      if (call_req) begin
        if (full) err <= 1'b1;
        else      count <= count + CW'(1);
      end else if (ret_req) begin
        if (empty) err <= 1'b1;
        else       count <= count - CW'(1);
      end
    end
  end

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && full) |=> (full && err));

  a_r9_empty_err: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && empty) |=> (empty && err));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int WW   = WORD_W,
  parameter int OPW  = OPC_W,
  parameter int FLW  = FLAG_W,
  parameter int BASE = DISP_BASE,
  parameter int SHF  = DISP_SHIFT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  car,
  input  logic [WW-1:0]  word,
  input  logic [OPW-1:0] opcode,
  input  logic [FLW-1:0] flags,
  input  logic           stk_empty,
  input  logic [AW-1:0]  stk_top,
  output logic [AW-1:0]  nxt,
  output logic [AW-1:0]  ret_addr,
  output logic           call_req,
  output logic           ret_req
);

  logic          is_br;
  br_op_e        op;
  logic [1:0]    sel;
  logic [AW-1:0] tgt;
  logic [AW-1:0] inc;
  logic [AW-1:0] disp;
  logic          flag_hit;
  logic          unused_bits;

  assign is_br       = word[FMT_BIT];
  assign op          = br_op_e'(word[OP_HI:OP_LO]);
  assign sel         = word[SEL_HI:SEL_LO];
  assign tgt         = word[AW-1:0];
  assign inc         = car + AW'(1);
  assign disp        = AW'(BASE) + (AW'(opcode) << SHF);
  assign flag_hit    = flags[sel];
  assign ret_addr    = inc;
  assign unused_bits = ^{word[11:10], word[7:6]};

  always_comb begin
    nxt      = inc;
    call_req = 1'b0;
    ret_req  = 1'b0;
    if (is_br) begin
      case (op)
        BR_JUMP: nxt = tgt;
        BR_JCND: nxt = flag_hit ? tgt : inc;
        BR_DISP: nxt = disp;
        BR_CALL: begin
          call_req = 1'b1;
          nxt      = tgt;
        end
        BR_RET: begin
          ret_req = 1'b1;
          nxt     = stk_empty ? inc : stk_top;
        end
        default: nxt = inc;
      endcase
    end
  end

  a_r2_control_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !word[FMT_BIT] |=> car == $past(car) + AW'(1));

  a_r4_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (word[FMT_BIT] && word[OP_HI:OP_LO] == 3'd1) |=> car == $past(word[AW-1:0]));

  a_r5_cond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (word[FMT_BIT] && word[OP_HI:OP_LO] == 3'd2 && flags[word[SEL_HI:SEL_LO]])
      |=> car == $past(word[AW-1:0]));

  a_r5_cond_fallthru: assert property (@(posedge clk) disable iff (!rst_n)
    (word[FMT_BIT] && word[OP_HI:OP_LO] == 3'd2 && !flags[word[SEL_HI:SEL_LO]])
      |=> car == $past(car) + AW'(1));

  a_r6_dispatch_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (word[FMT_BIT] && word[OP_HI:OP_LO] == 3'd3)
      |=> (car - AW'(BASE)) == ($past(AW'(opcode)) << SHF));

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int WW  = WORD_W,
  parameter int OPW = OPC_W,
  parameter int FLW = FLAG_W,
  parameter int SD  = STACK_D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  input  logic [FLW-1:0] flags,
  output logic [WW-2:0]  ctrl,
  output logic [AW-1:0]  uaddr,
  output logic           stk_err
);

  localparam int CW = WW - 1;

  logic [AW-1:0] car;
  logic [AW-1:0] car_nxt;
  logic [WW-1:0] cbr;
  logic [AW-1:0] ret_addr;
  logic [AW-1:0] stk_top;
  logic          stk_empty;
  logic          call_req;
  logic          ret_req;

  useq_store #(.AW(AW), .WW(WW)) u_store (
    .addr (car),
    .word (cbr)
  );

  useq_next #(
    .AW(AW), .WW(WW), .OPW(OPW), .FLW(FLW),
    .BASE(DISP_BASE), .SHF(DISP_SHIFT)
  ) u_next (
    .clk       (clk),
    .rst_n     (rst_n),
    .car       (car),
    .word      (cbr),
    .opcode    (opcode),
    .flags     (flags),
    .stk_empty (stk_empty),
    .stk_top   (stk_top),
    .nxt       (car_nxt),
    .ret_addr  (ret_addr),
    .call_req  (call_req),
    .ret_req   (ret_req)
  );

  useq_stack #(.AW(AW), .DEPTH(SD)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .push_addr (ret_addr),
    .top       (stk_top),
    .empty     (stk_empty),
    .err       (stk_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) car <= '0;
    else        car <= car_nxt;
  end

  assign uaddr = car;
  assign ctrl  = cbr[WW-1] ? '0 : cbr[CW-1:0];

  a_r1_reset_fetch: assert property (@(posedge clk)
    !rst_n |=> (uaddr == '0 && !stk_err));

  a_r7_return_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !stk_empty) |=> uaddr == $past(stk_top));

  a_r8_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> uaddr == $past(cbr[AW-1:0]));

endmodule

// File: tb/useq_sequencer_test.sv
module useq_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  opcode = '0;
  logic [3:0]  flags = '0;
  logic [14:0] ctrl;
  logic [5:0]  uaddr;
  logic        stk_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  useq_sequencer uut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .flags(flags),
    .ctrl(ctrl), .uaddr(uaddr), .stk_err(stk_err)
  );

  // {opcode, flags, expected address}
  localparam int NV = 59;
  localparam logic [12:0] VEC [NV] = '{
    {3'd0,4'h0,6'd0},{3'd0,4'h0,6'd1},{3'd0,4'h0,6'd2},{3'd0,4'h0,6'd3},
    {3'd0,4'h0,6'd16},{3'd0,4'h0,6'd17},
    {3'd1,4'h0,6'd0},{3'd1,4'h0,6'd1},{3'd1,4'h0,6'd2},{3'd1,4'h0,6'd3},
    {3'd1,4'h0,6'd20},{3'd1,4'h0,6'd21},{3'd1,4'h0,6'd22},
    {3'd1,4'h1,6'd0},{3'd1,4'h1,6'd1},{3'd1,4'h1,6'd2},{3'd1,4'h1,6'd3},
    {3'd1,4'h1,6'd20},{3'd1,4'h1,6'd48},{3'd1,4'h1,6'd49},
    {3'd2,4'h0,6'd0},{3'd2,4'h0,6'd1},{3'd2,4'h0,6'd2},{3'd2,4'h0,6'd3},
    {3'd2,4'h0,6'd24},{3'd2,4'h0,6'd52},{3'd2,4'h0,6'd53},{3'd2,4'h0,6'd25},
    {3'd2,4'h0,6'd26},
    {3'd3,4'h8,6'd0},{3'd3,4'h8,6'd1},{3'd3,4'h8,6'd2},{3'd3,4'h8,6'd3},
    {3'd3,4'h8,6'd28},{3'd3,4'h8,6'd56},{3'd3,4'h8,6'd57},
    {3'd3,4'h7,6'd0},{3'd3,4'h7,6'd1},{3'd3,4'h7,6'd2},{3'd3,4'h7,6'd3},
    {3'd3,4'h7,6'd28},{3'd3,4'h7,6'd29},
    {3'd4,4'h0,6'd0},{3'd4,4'h0,6'd1},{3'd4,4'h0,6'd2},{3'd4,4'h0,6'd3},
    {3'd4,4'h0,6'd32},{3'd4,4'h0,6'd58},{3'd4,4'h0,6'd52},{3'd4,4'h0,6'd53},
    {3'd4,4'h0,6'd59},{3'd4,4'h0,6'd33},
    {3'd7,4'h0,6'd0},{3'd7,4'h0,6'd1},{3'd7,4'h0,6'd2},{3'd7,4'h0,6'd3},
    {3'd7,4'h0,6'd44},{3'd7,4'h0,6'd45},{3'd7,4'h0,6'd46}
  };

  // control words of the resident program (R12)
  function automatic logic [14:0] exp_ctrl(logic [5:0] a);
    case (a)
      6'd0:  return 15'h0001;
      6'd1:  return 15'h0002;
      6'd2:  return 15'h0004;
      6'd16: return 15'h0010;
      6'd21: return 15'h0020;
      6'd25: return 15'h0080;
      6'd41: return 15'h0400;
      6'd45: return 15'h0800;
      6'd48: return 15'h0040;
      6'd52: return 15'h0100;
      6'd56: return 15'h0200;
      default: return 15'h0000;
    endcase
  endfunction

  // requirement that decided the move away from the previous address
  function automatic string step_tag(int prev);
    case (prev)
      -1: return "R1";
      3:  return "R6";
      20, 28: return "R5";
      24, 32, 58, 53, 59: return "R7";
      44: return "R3";
      17, 22, 26, 29, 33, 42, 46, 49, 57: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic reset_for(int n);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (n) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: state right after reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset address", 32'(uaddr), 32'd0);
    check("R1 reset error", 32'(stk_err), 32'd0);
    check("R1 reset fetch ctrl", 32'(ctrl), 32'h0001);

    // table walk: one row per cycle
    for (int i = 0; i < NV; i++) begin
      logic [2:0] vo;
      logic [3:0] vf;
      logic [5:0] va;
      int         prev;
      {vo, vf, va} = VEC[i];
      prev = (i == 0) ? -1 : int'(VEC[i-1][5:0]);
      opcode = vo;
      flags  = vf;
      #1;
      check(step_tag(prev), 32'(uaddr), 32'(va));
      // nonzero flags or opcode away from decision points: R11
      check((vf != 0 || vo != 0) ? "R11 ctrl" : "R12 ctrl",
            32'(ctrl), 32'(exp_ctrl(va)));
      check("R10 no error", 32'(stk_err), 32'd0);
      @(negedge clk);
    end

    // R8: runaway self-call overflows on the fifth call
    opcode = 3'd5;
    flags  = 4'h0;
    reset_for(2);
    step(8);
    #1;
    check("R8 before overflow addr", 32'(uaddr), 32'd36);
    check("R8 before overflow err", 32'(stk_err), 32'd0);
    check("R3 branch word ctrl quiet", 32'(ctrl), 32'd0);
    step(1);
    #1;
    check("R8 overflow err", 32'(stk_err), 32'd1);
    check("R8 call still jumps", 32'(uaddr), 32'd36);
    opcode = 3'd0;
    step(1);
    #1;
    check("R10 err held", 32'(stk_err), 32'd1);

    // R1: reset clears a sticky error
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check("R1 reset clears err", 32'(stk_err), 32'd0);
    check("R1 reset clears addr", 32'(uaddr), 32'd0);
    rst_n = 1'b1;

    // reset in the middle of a nested call, then return on empty stack
    opcode = 3'd4;
    step(6);
    #1;
    check("R7 inside nested call", 32'(uaddr), 32'd52);
    @(negedge clk);
    rst_n = 1'b0;
    opcode = 3'd6;
    @(negedge clk);
    rst_n = 1'b1;
    step(4);
    #1;
    check("R6 dispatch opcode 6", 32'(uaddr), 32'd40);
    check("R9 before underflow", 32'(stk_err), 32'd0);
    step(1);
    #1;
    check("R9 underflow steps on", 32'(uaddr), 32'd41);
    check("R9 underflow err (R1 emptied stack)", 32'(stk_err), 32'd1);
    check("R2 ctrl after underflow", 32'(ctrl), 32'h0400);
    step(2);
    #1;
    check("R10 err sticky at fetch", 32'(stk_err), 32'd1);
    check("R4 back to fetch", 32'(uaddr), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule